// File: doc/BRIEF.md
# System Address Range Decoder

This block turns a physical address into a socket, a memory controller and a channel. Before any decode, software loads the tables through a single register-write port. Each socket has its own table set: a list of up to 24 address-range entries, one interleave word per entry, a route word, and a 3-bit source ID. Two bounds are shared by all sockets: the top of low memory and the top of high memory.

A decode starts with a valid/ready request. The address is first checked against the two bounds. The block then scans the range entries of socket table 0, one entry per clock. When an entry matches, address bits chosen by the entry select a 4-bit target from its interleave word. A target can point to another socket. In that case the scan restarts once in the table whose source ID matches. If the target is local, a logical channel is formed, either directly from the target or by a modulo-3 or modulo-2 fold of the shifted address. The logical channel then picks the controller and channel fields out of the route word.

The result is returned through a valid/ready response with an error code. The block takes no new request until that response has been accepted.

Top module: `sard_top`

## Requirements
- R1: An address at or above the high bound, or at or above the low bound and below 2^32, is answered with error code 1 and no scan.
- R2: Range entries are tried in index order. An entry's limit is its word bits [26:7] shifted left by 26, with the low 26 bits set to ones. An entry matches when bit 0 is set and the address lies between the previous entry's limit plus one (0 for entry 0) and its own limit. Every entry moves the lower bound on, whether it is enabled or not.
- R3: If none of the 24 entries match, the response has error code 2.
- R4: Entry bits [2:1] select the 3-bit interleave index: 0 gives address [8:6], 1 gives [10:8], 2 gives [14:12], 3 gives [32:30].
- R5: The index selects the nibble at bit 4*index of the interleave word. Nibble bit 3 set means local. When entry bit 27 is clear, the logical channel is nibble bits [2:0].
- R6: A nibble with bit 3 clear names node [2:0]. The scan restarts from entry 0 in the lowest socket table whose source ID equals the node. No such table gives error code 4. A second remote nibble in the same decode gives error code 3.
- R7: When bit 27 is set, bits [31:30] pick a shift of 6, 8 or 12. The value 3 gives error code 5.
- R8: With the shifted address v, bits [6:5] pick a base value: 0 gives v mod 3; 1 gives v mod 2; 2 gives {v[0], not v[0]}; 3 gives {v[0], 0}. The logical channel is {base, nibble bit 0}.
- R9: On success the error code is 0. The controller is route bits [3*lchan +: 3] and the channel is route bits [18+2*lchan +: 2], reading bits above 31 as zero. The socket output is the source ID of the table that resolved the address.
- R10: req_ready is high only when idle. Once a request is accepted, req_ready stays low until the response has been taken. While rsp_valid is high and rsp_ready is low, the response does not change.
- R11: An error response (code 1 to 5) carries zero socket, controller and channel fields. No other code value appears.
- R12: After reset, req_ready is 1 and rsp_valid is 0.
- R13: cfg_kind selects the write target: 0 is a range entry, 1 is an interleave word, 2 is a route word, 3 is a source ID (data bits [2:0]), 4 is the low bound, 5 is the high bound. Reset clears every table and both bounds to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Write target select |
| cfg_sock | input | SOCK_W | Socket table written |
| cfg_idx | input | IDX_W | Entry index for range and interleave writes |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Decode request valid |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | ADDR_W | Physical address to decode |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed |
| rsp_err | output | 3 | Error code (0 is success) |
| rsp_socket | output | 3 | Resolved socket source ID |
| rsp_mc | output | 3 | Memory controller number |
| rsp_chan | output | 2 | Channel number |

## Verification
The bench sends addresses that sit exactly on the bounds, on the 4 GiB edge and on an entry limit. These separate inclusive compares from exclusive ones. A disabled entry placed in the middle of the table checks that the lower bound still moves on past it. Index-bit sweeps under each of the four selection modes and each fold form produce logical channels 0 to 7. Those values tell apart wrong bit picks, wrong shifts and wrong route-field offsets. The remote-target cases run a local hit after a redirect, a second redirect, and a node with no matching table, which splits error codes 3 and 4 from a plain success in the other socket. A held-back response shows that the result stays stable and that the block refuses new work while it waits.

// File: rtl/sard_pkg.sv
package sard_pkg;

    localparam int LIM_SHIFT = 26;

    typedef enum logic [2:0] {
        DEC_OK            = 3'd0,
        DEC_OUT_OF_RANGE  = 3'd1,
        DEC_NO_ENTRY      = 3'd2,
        DEC_DOUBLE_REMOTE = 3'd3,
        DEC_UNKNOWN_NODE  = 3'd4,
        DEC_BAD_MOD3      = 3'd5
    } dec_err_e;

    typedef enum logic [2:0] {
        CFG_RANGE    = 3'd0,
        CFG_ILV      = 3'd1,
        CFG_ROUTE    = 3'd2,
        CFG_SRCID    = 3'd3,
        CFG_LOW_TOP  = 3'd4,
        CFG_HIGH_TOP = 3'd5
    } cfg_kind_e;

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} dec_state_e;

    // Only the fields the decode uses are kept from a range word.
    typedef struct packed {
        logic [1:0]  fold_shift_sel;
        logic        fold_en;
        logic [19:0] limit_hi;
        logic [1:0]  fold_form;
        logic [1:0]  pick_mode;
        logic        enable;
    } range_ent_t;

    function automatic range_ent_t unpack_range(input logic [31:0] w);
        range_ent_t e;
        e.fold_shift_sel = w[31:30];
        e.fold_en        = w[27];
        e.limit_hi       = w[26:7];
        e.fold_form      = w[6:5];
        e.pick_mode      = w[2:1];
        e.enable         = w[0];
        return e;
    endfunction

    function automatic logic [63:0] range_limit(input logic [19:0] f);
        return ({44'd0, f} << LIM_SHIFT) | 64'h0000_0000_03FF_FFFF;
    endfunction

    // Remainder modulo 3, folding one bit at a time from the top.
    function automatic logic [1:0] mod3_of(input logic [63:0] v);
        logic [1:0] r;
        r = 2'd0;
        for (int i = 63; i >= 0; i--) begin
            case ({r, v[i]})
                3'b000:  r = 2'd0;
                3'b001:  r = 2'd1;
                3'b010:  r = 2'd2;
                3'b011:  r = 2'd0;
                3'b100:  r = 2'd1;
                3'b101:  r = 2'd2;
                default: r = 2'd0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sard_cfg_store.sv
module sard_cfg_store
    import sard_pkg::*;
#(
    parameter int ADDR_W    = 46,
    parameter int NUM_SOCK  = 2,
    parameter int NUM_RANGE = 24,
    parameter int SOCK_W    = 1,
    parameter int IDX_W     = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [2:0]               kind,
    input  logic [SOCK_W-1:0]        wsock,
    input  logic [IDX_W-1:0]         widx,
    input  logic [ADDR_W-1:0]        wdata,
    input  logic [SOCK_W-1:0]        rd_sock,
    input  logic [IDX_W-1:0]         rd_idx,
    output range_ent_t               rd_range,
    output logic [31:0]              rd_ilv,
    output logic [31:0]              rd_route,
    output logic [NUM_SOCK-1:0][2:0] src_ids,
    output logic [ADDR_W-1:0]        low_top,
    output logic [ADDR_W-1:0]        high_top
);

    range_ent_t  rng_q   [NUM_SOCK][NUM_RANGE];
    logic [31:0] ilv_q   [NUM_SOCK][NUM_RANGE];
    logic [31:0] route_q [NUM_SOCK];
    logic [NUM_SOCK-1:0][2:0] src_q;
    logic [ADDR_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SOCK; s++) begin
                for (int i = 0; i < NUM_RANGE; i++) begin
                    rng_q[s][i] <= '0;
                    ilv_q[s][i] <= '0;
                end
                route_q[s] <= '0;
            end
            src_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (we && (int'(wsock) < NUM_SOCK)) begin
            case (cfg_kind_e'(kind))
                CFG_RANGE:    if (int'(widx) < NUM_RANGE) rng_q[wsock][widx] <= unpack_range(wdata[31:0]);
                CFG_ILV:      if (int'(widx) < NUM_RANGE) ilv_q[wsock][widx] <= wdata[31:0];
                CFG_ROUTE:    route_q[wsock] <= wdata[31:0];
                CFG_SRCID:    src_q[wsock]   <= wdata[2:0];
                CFG_LOW_TOP:  lo_q <= wdata;
                CFG_HIGH_TOP: hi_q <= wdata;
                default: ;
            endcase
        end
    end

    assign rd_range = rng_q[rd_sock][rd_idx];
    assign rd_ilv   = ilv_q[rd_sock][rd_idx];
    assign rd_route = route_q[rd_sock];
    assign src_ids  = src_q;
    assign low_top  = lo_q;
    assign high_top = hi_q;

endmodule

// File: rtl/sard_lane_calc.sv
module sard_lane_calc
    import sard_pkg::*;
#(
    parameter int ADDR_W = 46
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        pick_mode,
    input  logic              fold_en,
    input  logic [1:0]        fold_shift_sel,
    input  logic [1:0]        fold_form,
    input  logic [31:0]       ilv_word,
    input  logic [31:0]       route_word,
    output logic              remote,
    output logic [2:0]        node,
    output logic              bad_mode,
    output logic [2:0]        mc,
    output logic [1:0]        chan
);

    logic [63:0] a64, folded, r64;
    logic [2:0]  pick, lchan;
    logic [3:0]  tgt;
    logic [5:0]  sh_amt;
    logic [1:0]  base;
    logic        odd;

    always_comb begin
        a64 = 64'(addr);
        case (pick_mode)
            2'd0:    pick = a64[8:6];
            2'd1:    pick = a64[10:8];
            2'd2:    pick = a64[14:12];
            default: pick = a64[32:30];
        endcase
        tgt    = ilv_word[{pick, 2'b00} +: 4];
        remote = ~tgt[3];
        node   = tgt[2:0];

        case (fold_shift_sel)
            2'd0:    sh_amt = 6'd6;
            2'd1:    sh_amt = 6'd8;
            2'd2:    sh_amt = 6'd12;
            default: sh_amt = 6'd0;
        endcase
        bad_mode = fold_en && (fold_shift_sel == 2'd3);
        folded   = a64 >> sh_amt;
        odd      = folded[0];
        case (fold_form)
            2'd0:    base = mod3_of(folded);
            2'd1:    base = {1'b0, odd};
            2'd2:    base = {odd, ~odd};
            default: base = {odd, 1'b0};
        endcase
        lchan = fold_en ? {base, tgt[0]} : tgt[2:0];

        r64  = {32'd0, route_word};
        mc   = r64[int'(lchan) * 3 +: 3];
        chan = r64[18 + 2 * int'(lchan) +: 2];
    end

endmodule

// File: rtl/sard_node_find.sv
module sard_node_find #(
    parameter int NUM_SOCK = 2,
    parameter int SOCK_W   = 1
) (
    input  logic [NUM_SOCK-1:0][2:0] src_ids,
    input  logic [2:0]               node,
    output logic                     found,
    output logic [SOCK_W-1:0]        sel
);

    logic [NUM_SOCK-1:0] match;

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_cmp
        assign match[g] = (src_ids[g] == node);
    end

    // Lowest-numbered matching table wins.
    always_comb begin
        found = |match;
        sel   = '0;
        for (int i = NUM_SOCK - 1; i >= 0; i--) begin
            if (match[i]) sel = SOCK_W'(i);
        end
    end

endmodule

// File: rtl/sard_top.sv
module sard_top
    import sard_pkg::*;
#(
    parameter int ADDR_W    = 46,
    parameter int NUM_SOCK  = 2,
    parameter int NUM_RANGE = 24,
    localparam int SOCK_W   = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
    localparam int IDX_W    = (NUM_RANGE > 1) ? $clog2(NUM_RANGE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_kind,
    input  logic [SOCK_W-1:0] cfg_sock,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_err,
    output logic [2:0]        rsp_socket,
    output logic [2:0]        rsp_mc,
    output logic [1:0]        rsp_chan
);

    dec_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SOCK_W-1:0] sock_q;
    logic [IDX_W-1:0]  idx_q;
    logic [63:0]       prev_q;
    logic              redirected_q;
    dec_err_e          err_q;
    logic [2:0]        soc_q, mc_q;
    logic [1:0]        ch_q;

    range_ent_t                ent;
    logic [31:0]               ilv_w, route_w;
    logic [NUM_SOCK-1:0][2:0]  src_ids;
    logic [ADDR_W-1:0]         low_top, high_top;
    logic                      ln_remote, ln_bad, nd_found;
    logic [2:0]                ln_node, ln_mc;
    logic [1:0]                ln_chan;
    logic [SOCK_W-1:0]         nd_sel;

    sard_cfg_store #(
        .ADDR_W(ADDR_W), .NUM_SOCK(NUM_SOCK), .NUM_RANGE(NUM_RANGE),
        .SOCK_W(SOCK_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst(rst), .we(cfg_we), .kind(cfg_kind),
        .wsock(cfg_sock), .widx(cfg_idx), .wdata(cfg_wdata),
        .rd_sock(sock_q), .rd_idx(idx_q), .rd_range(ent),
        .rd_ilv(ilv_w), .rd_route(route_w), .src_ids(src_ids),
        .low_top(low_top), .high_top(high_top)
    );

    sard_lane_calc #(.ADDR_W(ADDR_W)) u_lane (
        .addr(addr_q), .pick_mode(ent.pick_mode), .fold_en(ent.fold_en),
        .fold_shift_sel(ent.fold_shift_sel), .fold_form(ent.fold_form),
        .ilv_word(ilv_w), .route_word(route_w), .remote(ln_remote),
        .node(ln_node), .bad_mode(ln_bad), .mc(ln_mc), .chan(ln_chan)
    );

    sard_node_find #(.NUM_SOCK(NUM_SOCK), .SOCK_W(SOCK_W)) u_find (
        .src_ids(src_ids), .node(ln_node), .found(nd_found), .sel(nd_sel)
    );

    logic [63:0] lim64, addr64, req64;
    logic        hit, out_of_range;

    always_comb begin
        lim64        = range_limit(ent.limit_hi);
        addr64       = 64'(addr_q);
        req64        = 64'(req_addr);
        hit          = ent.enable && (addr64 >= prev_q) && (addr64 <= lim64);
        out_of_range = (req64 >= 64'(high_top)) ||
                       ((req64 >= 64'(low_top)) && (req64 < 64'h1_0000_0000));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE; addr_q <= '0; sock_q <= '0; idx_q <= '0;
            prev_q <= '0; redirected_q <= 1'b0; err_q <= DEC_OK;
            soc_q <= '0; mc_q <= '0; ch_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    addr_q <= req_addr; sock_q <= '0; idx_q <= '0;
                    prev_q <= '0; redirected_q <= 1'b0;
                    soc_q <= '0; mc_q <= '0; ch_q <= '0;
                    if (out_of_range) begin
                        err_q <= DEC_OUT_OF_RANGE; st_q <= ST_DONE;
                    end else begin
                        err_q <= DEC_OK; st_q <= ST_SCAN;
                    end
                end
                ST_SCAN: if (hit) begin
                    if (ln_remote) begin
                        if (redirected_q) begin
                            err_q <= DEC_DOUBLE_REMOTE; st_q <= ST_DONE;
                        end else if (!nd_found) begin
                            err_q <= DEC_UNKNOWN_NODE; st_q <= ST_DONE;
                        end else begin
                            sock_q <= nd_sel; idx_q <= '0; prev_q <= '0;
                            redirected_q <= 1'b1;
                        end
                    end else if (ln_bad) begin
                        err_q <= DEC_BAD_MOD3; st_q <= ST_DONE;
                    end else begin
                        soc_q <= src_ids[sock_q]; mc_q <= ln_mc; ch_q <= ln_chan;
                        st_q  <= ST_DONE;
                    end
                end else begin
                    prev_q <= lim64 + 64'd1;
                    if (idx_q == IDX_W'(NUM_RANGE - 1)) begin
                        err_q <= DEC_NO_ENTRY; st_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DONE: if (rsp_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign rsp_valid  = (st_q == ST_DONE);
    assign rsp_err    = err_q;
    assign rsp_socket = soc_q;
    assign rsp_mc     = mc_q;
    assign rsp_chan   = ch_q;

endmodule

// File: rtl/sard_chk.sv
module sard_chk #(
    parameter int NUM_RANGE = 24
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [2:0] rsp_err,
    input logic [2:0] rsp_socket,
    input logic [2:0] rsp_mc,
    input logic [1:0] rsp_chan
);

    logic        scanning;
    logic [15:0] scan_cnt;

    assign scanning = !req_ready && !rsp_valid;

    always_ff @(posedge clk) begin
        if (rst)           scan_cnt <= '0;
        else if (scanning) scan_cnt <= scan_cnt + 16'd1;
        else               scan_cnt <= '0;
    end

    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) &&
            $stable(rsp_socket) && $stable(rsp_mc) && $stable(rsp_chan)));

    p_err_fields_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err != 3'd0) |-> (rsp_socket == 3'd0 && rsp_mc == 3'd0 && rsp_chan == 2'd0));

    p_err_code_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err <= 3'd5));

    // R3: at most one full table walk plus one after a redirect.
    p_scan_limit_r3: assert property (@(posedge clk) disable iff (rst)
        scanning |-> (scan_cnt < 16'(2 * NUM_RANGE)));

endmodule

bind sard_top sard_chk #(.NUM_RANGE(NUM_RANGE)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_socket(rsp_socket), .rsp_mc(rsp_mc), .rsp_chan(rsp_chan)
);

// File: tb/sard_top_tb_top.sv
`timescale 1ns/1ps
module sard_top_tb_top;

    localparam int AW = 46;
    localparam int NS = 2;
    localparam int NR = 24;

    typedef struct packed {
        logic [2:0] err;
        logic [2:0] soc;
        logic [2:0] mc;
        logic [1:0] ch;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_kind = '0;
    logic          cfg_sock = 1'b0;
    logic [4:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [2:0]    rsp_err, rsp_socket, rsp_mc;
    logic [1:0]    rsp_chan;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] m_rng [NS][NR];
    logic [31:0] m_ilv [NS][NR];
    logic [31:0] m_route [NS];
    logic [2:0]  m_src [NS];
    logic [63:0] m_lo, m_hi;

    always #2 clk = ~clk;

    sard_top #(.ADDR_W(AW), .NUM_SOCK(NS), .NUM_RANGE(NR)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_sock(cfg_sock), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
        .rsp_socket(rsp_socket), .rsp_mc(rsp_mc), .rsp_chan(rsp_chan)
    );

    // Reference decode written from the requirements.
    function automatic exp_t model(input logic [63:0] a);
        exp_t r;
        int s, i, found, sh;
        bit redir, done;
        logic [63:0] prev, lim, v, rt;
        logic [31:0] w;
        logic [2:0] idx, l;
        logic [3:0] tgt;
        logic [1:0] b;
        r = '0; s = 0; i = 0; redir = 0; done = 0; prev = 0;
        if (a >= m_hi || (a >= m_lo && a < 64'h1_0000_0000)) begin
            r.err = 3'd1; return r;
        end
        while (!done) begin
            if (i == NR) begin r.err = 3'd2; done = 1; end
            else begin
                w = m_rng[s][i];
                lim = ({44'd0, w[26:7]} << 26) | 64'h3FF_FFFF;
                if (w[0] && a >= prev && a <= lim) begin
                    case (w[2:1])
                        2'd0: idx = a[8:6];
                        2'd1: idx = a[10:8];
                        2'd2: idx = a[14:12];
                        default: idx = a[32:30];
                    endcase
                    tgt = 4'((m_ilv[s][i] >> (4 * idx)) & 32'hF);
                    if (!tgt[3]) begin
                        found = -1;
                        for (int k = NS - 1; k >= 0; k--) if (m_src[k] == tgt[2:0]) found = k;
                        if (redir) begin r.err = 3'd3; done = 1; end
                        else if (found < 0) begin r.err = 3'd4; done = 1; end
                        else begin s = found; redir = 1; i = 0; prev = 0; end
                    end else begin
                        sh = -1;
                        if (!w[27]) l = tgt[2:0];
                        else begin
                            case (w[31:30])
                                2'd0: sh = 6;
                                2'd1: sh = 8;
                                2'd2: sh = 12;
                                default: sh = -1;
                            endcase
                            if (sh >= 0) begin
                                v = a >> sh;
                                case (w[6:5])
                                    2'd0: b = 2'(v % 3);
                                    2'd1: b = {1'b0, v[0]};
                                    2'd2: b = {v[0], ~v[0]};
                                    default: b = {v[0], 1'b0};
                                endcase
                                l = {b, tgt[0]};
                            end
                        end
                        if (w[27] && sh < 0) r.err = 3'd5;
                        else begin
                            rt = {32'd0, m_route[s]};
                            r.mc  = 3'((rt >> (3 * l)) & 64'h7);
                            r.ch  = 2'((rt >> (18 + 2 * l)) & 64'h3);
                            r.soc = m_src[s];
                        end
                        done = 1;
                    end
                end else begin
                    prev = lim + 1; i++;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] rw(input bit en, input int mode, input int form,
                                       input bit fold, input int shsel, input int f);
        return (32'(shsel) << 30) | (32'(fold) << 27) | (32'(f) << 7) |
               (32'(form) << 5) | (32'(mode) << 1) | 32'(en);
    endfunction

    task automatic wr(input int kind, input int sock, input int idx, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_sock = sock[0];
        cfg_idx = 5'(idx); cfg_wdata = AW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        case (kind)
            0: m_rng[sock][idx] = d[31:0];
            1: m_ilv[sock][idx] = d[31:0];
            2: m_route[sock] = d[31:0];
            3: m_src[sock] = d[2:0];
            4: m_lo = 64'(AW'(d));
            5: m_hi = 64'(AW'(d));
            default: ;
        endcase
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic send(input logic [63:0] a, input string tag);
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
    endtask

    // Monitor: compare each consumed response with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: unexpected response actual err %0d expected none", rsp_err);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rsp_err != e.err || rsp_socket != e.soc || rsp_mc != e.mc || rsp_chan != e.ch) begin
                    errors++;
                    $display("FAIL %s: err/soc/mc/ch actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                             t, rsp_err, rsp_socket, rsp_mc, rsp_chan, e.err, e.soc, e.mc, e.ch);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            for (int i = 0; i < NR; i++) begin m_rng[s][i] = '0; m_ilv[s][i] = '0; end
            m_route[s] = '0; m_src[s] = '0;
        end
        m_lo = '0; m_hi = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R12 ready after reset", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R12 no response after reset", int'(rsp_valid), 0);

        // R13: cleared bounds reject everything.
        send(64'h1000, "R13 reset bounds");

        wr(4, 0, 0, 64'h8000_0000);
        wr(5, 0, 0, 64'h10_0000_0000);
        wr(3, 0, 0, 64'd0);
        wr(3, 1, 0, 64'd1);
        wr(2, 0, 0, 64'hB5E3_9C71);
        wr(2, 1, 0, 64'h4A1D_72C6);
        wr(0, 0, 0, 64'(rw(1, 0, 0, 0, 0, 1)));
        wr(0, 0, 1, 64'(rw(0, 0, 0, 0, 0, 2)));
        wr(0, 0, 2, 64'(rw(1, 0, 0, 1, 0, 3)));
        wr(0, 0, 3, 64'(rw(1, 2, 1, 1, 1, 4)));
        wr(0, 0, 4, 64'(rw(1, 3, 2, 1, 2, 5)));
        wr(0, 0, 5, 64'(rw(1, 1, 3, 1, 0, 6)));
        wr(0, 0, 6, 64'(rw(1, 0, 0, 1, 3, 7)));
        wr(0, 0, 7, 64'(rw(1, 0, 0, 0, 0, 8)));
        wr(0, 0, 8, 64'(rw(1, 0, 0, 0, 0, 9)));
        for (int i = 0; i < 7; i++) wr(1, 0, i, 64'hFEDC_BA98);
        wr(1, 0, 7, 64'h1111_1111);
        wr(1, 0, 8, 64'h5555_5555);
        wr(0, 1, 0, 64'(rw(1, 0, 0, 0, 0, 8)));
        wr(1, 1, 0, 64'h0E0C_0A08);

        send(64'h8000_0000, "R1 at low bound");
        send(64'hFFFF_FFFF, "R1 below 4GiB");
        send(64'h10_0000_0000, "R1 at high bound");
        send(64'h10_0000_0005, "R1 above high bound");
        send(64'h1_0000_0000, "R3 4GiB not rejected");
        send(64'hF_FFFF_FFFF, "R3 below high bound");
        send(64'h7FFF_FFFF, "R1 just under low bound");

        for (int k = 0; k < 8; k++) send(64'h40 * k, "R5 direct lane");
        send(64'h07FF_FFFF, "R2 inclusive limit");
        send(64'h0900_0000, "R2 disabled entry advances bound");
        send(64'h0C00_0000, "R2 first address past hole");

        for (int k = 0; k < 6; k++) send(64'h0C00_0000 + 64'h40 * k, "R8 mod3 fold");
        for (int k = 0; k < 4; k++) send(64'h1000_0000 + 64'h100 * k + 64'h1000 * k, "R4 mid bits pick");
        for (int k = 0; k < 4; k++) send(64'h1400_0000 + 64'h1000 * k, "R8 swapped pair");
        for (int k = 0; k < 4; k++) send(64'h1800_0000 + 64'h40 * k + 64'h100 * (k / 2), "R8 doubled fold");
        send(64'h1C00_0000, "R7 illegal shift select");
        send(64'h1C12_3440, "R7 illegal shift select 2");

        send(64'h2000_0000, "R6 remote then local");
        send(64'h2000_0080, "R9 remote lane 2");
        send(64'h2000_0040, "R6 double remote");
        send(64'h2400_0000, "R6 unknown node");
        send(64'h2800_0000, "R3 past last entry");

        // R10: response held while not consumed.
        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        rsp_ready = 1'b0;
        send(64'h0000_00C0, "R10 held response");
        repeat (6) @(negedge clk);
        check(rsp_valid == 1'b1, "R10 response held", int'(rsp_valid), 1);
        check(req_ready == 1'b0, "R10 still busy", int'(req_ready), 0);
        rsp_ready = 1'b1;

        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 idle after consume", int'(req_ready), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule